// File: doc/BRIEF.md
# Dual-Width Register Bus Front End

This block sits between a host processor and a small bank of 16-bit registers inside a larger chip. The host issues one-cycle synchronous strobes: a chip select together with a read or a write. A registered read returns its data one cycle later. A strap input fixes the bus width. With the strap low, every access moves a whole 16-bit word. With the strap high, only the bottom eight data lines carry data, and data bit 15 selects the byte lane: low for the low byte, high for the high byte.

A byte-wide host often reads a word as two bytes while the underlying value keeps changing, as a live status word does. To give a consistent word, a low-byte read captures the high byte of the same word in a holding latch. A high-byte read of the same address that comes next returns the captured byte. Any other intervening access drops the latch, and the high-byte read then returns the live byte.

The bank holds these registers:

| Address | Register | Access |
|---|---|---|
| 0 to N_CTRL-1 | Control | Read/write |
| N_CTRL to N_CTRL+N_STAT-1 | Status, driven from the status inputs | Read-only |
| N_CTRL+N_STAT | Interrupt enable | Read/write |
| N_CTRL+N_STAT+1 | Interrupt pending | Write 1 to clear |

Each interrupt source owns one bit in the enable register and one bit in the pending register. An active-low interrupt request is driven whenever an enabled pending bit is set.

Top module: `regbus_front`

## Requirements
- R1: While rst_n is low at a clock edge, the control, enable and pending registers and the holding latch clear to zero. After that edge, rdata is 0 and irq_n is 1.
- R2: With mode8 low, a write (cs and wr high at a clock edge) to a control register stores wdata[15:0]. A read (cs and rd high) puts the full 16-bit word of the addressed register on rdata after the next clock edge, and rdata holds that value until the next read.
- R3: With mode8 high, a write stores wdata[7:0] into the low byte if wdata[15] is 0, or into the high byte if wdata[15] is 1. The other byte of the register keeps its value.
- R4: With mode8 high, a read returns the selected byte on rdata[7:0], chosen by wdata[15] as in R3, and returns 0 on rdata[15:8].
- R5: With mode8 high, a low-byte read of address A captures bits 15:8 of that word. If the very next access is a high-byte read of A, it returns the captured byte, even if the word has changed in between.
- R6: A high-byte read returns the live high byte in every other case: after a write, after a read of another address, after a high-byte read, or as the first access.
- R7: A write to an unassigned address, from N_CTRL+N_STAT+2 up to the top of the address range, changes no register. A read of such an address returns 0.
- R8: A status register read returns the current value of its slice of sts_in. A write to a status address is ignored.
- R9: A one-cycle pulse on evt[i] sets pending bit i, and the bit stays set until the host writes 1 to it at the pending address. Writing 0 to a pending bit leaves it unchanged. Enable and pending bits at or above N_IRQ read as 0.
- R10: irq_n is 0 exactly when some pending bit and its enable bit are both 1. It follows an event pulse or a clear write at the same clock edge that updates the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode8 | input | 1 | Width strap: 1 selects the 8-bit bus, 0 selects the 16-bit bus |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 16 | Write data; in 8-bit mode bit 15 is the byte-lane select |
| rdata | output | 16 | Registered read data |
| sts_in | input | N_STAT*16 | Live status words; word k is read at address N_CTRL+k |
| evt | input | N_IRQ | One-cycle interrupt event pulses |
| ctrl_out | output | N_CTRL*16 | Control register contents; word k is at address k |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench changes a status word between the two byte reads of one address. A design that did not latch would return a mixed word. A design that latched but never released the latch would return stale data after a write, after a read of another address, or after a second high-byte read. It sweeps both lanes of every control register and then reads back the untouched byte; a design with a wrong write mask would corrupt the neighbouring lane. It also writes across the unassigned and read-only addresses and then re-reads the whole map, which exposes loose decoding as aliasing. It pulses every interrupt source under a mixed enable mask and clears each source with a byte-wide write. This exposes pending bits that clear themselves, clear writes that reach the wrong lane, and a request that ignores the enable mask.

// File: rtl/regbus_pkg.sv
// Package: shared constants and helpers for the dual-width register front end.
// Assumes a 16-bit register word; bit 15 of the data bus doubles as the lane select.
package regbus_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANE_BIT = 15;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_STAT,
        TGT_IEN,
        TGT_IPEND
    } target_e;

    // Mask selecting which word bits a write touches.
    function automatic logic [WORD_W-1:0] lane_mask(input logic narrow, input logic hi);
        if (!narrow)
            return '1;
        return hi ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    endfunction
endpackage

// File: rtl/regbus_lane.sv
// Module: byte-lane steering. Builds the write word and mask from the host bus,
// and narrows a read word onto the selected lane. Purely combinational.
// Assumes the caller supplies the high-byte override (the holding latch result).
module regbus_lane
    import regbus_pkg::*;
(
    input  logic              mode8,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              use_held,
    input  logic [BYTE_W-1:0] held_byte,
    output logic              hi_sel,
    output logic [WORD_W-1:0] w_word,
    output logic [WORD_W-1:0] w_mask,
    output logic [WORD_W-1:0] rd_out
);
    // Lane select and write-side steering.
    always_comb begin
        hi_sel = mode8 & wdata[LANE_BIT];
        w_mask = lane_mask(mode8, wdata[LANE_BIT]);
        w_word = mode8 ? {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]} : wdata;
    end

    // Read-side narrowing onto the low eight data lines.
    always_comb begin
        if (!mode8)
            rd_out = rd_word;
        else if (hi_sel)
            rd_out = {{BYTE_W{1'b0}}, use_held ? held_byte : rd_word[WORD_W-1:BYTE_W]};
        else
            rd_out = {{BYTE_W{1'b0}}, rd_word[BYTE_W-1:0]};
    end
endmodule

// File: rtl/regbus_rdlatch.sv
// Module: holding latch for split word reads. A low-byte read captures the high
// byte of the same word. The capture is offered only to a high-byte read of the
// same address that is the very next access.
// Assumes 'access' marks every host strobe that the chip select qualifies.
module regbus_rdlatch
    import regbus_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              low_rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] live_hi,
    output logic              hit,
    output logic [BYTE_W-1:0] held
);
    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture on a low-byte read; any other access releases the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            held    <= '0;
        end else if (access) begin
            valid_q <= low_rd;
            if (low_rd) begin
                addr_q <= addr;
                held   <= live_hi;
            end
        end
    end

    // The latch applies only to the address it was captured from.
    always_comb hit = valid_q && (addr_q == addr);
endmodule

// File: rtl/regbus_irq.sv
// Module: interrupt enable and pending registers with an active-low request.
// Pending bits are set by event pulses and cleared by writing 1. When a set and
// a clear hit the same bit in the same cycle, the set wins.
module regbus_irq #(
    parameter int N_IRQ = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] evt,
    input  logic             en_we,
    input  logic             pend_we,
    input  logic [N_IRQ-1:0] w_word,
    input  logic [N_IRQ-1:0] w_mask,
    output logic [N_IRQ-1:0] en_q,
    output logic [N_IRQ-1:0] pend_q,
    output logic             irq_n
);
    logic [N_IRQ-1:0] clr;

    // Bits the host asks to clear this cycle.
    always_comb clr = pend_we ? (w_word & w_mask) : '0;

    // Enable register: masked read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we)
            en_q <= (en_q & ~w_mask) | (w_word & w_mask);
    end

    // Pending register: sticky set, write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | evt;
    end

    // Request aggregation.
    always_comb irq_n = ~|(en_q & pend_q);
endmodule

// File: rtl/regbus_front.sv
// Module: top of the dual-width register front end. Decodes the host address,
// holds the control registers, and muxes status words and interrupt registers
// onto a registered read port.
// Assumes one-cycle strobes sampled at the rising clock edge and a static mode8 strap.
module regbus_front
    import regbus_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int N_CTRL = 4,
    parameter int N_STAT = 2,
    parameter int N_IRQ  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode8,
    input  logic                     cs,
    input  logic                     rd,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata,
    input  logic [N_STAT*WORD_W-1:0] sts_in,
    input  logic [N_IRQ-1:0]         evt,
    output logic [N_CTRL*WORD_W-1:0] ctrl_out,
    output logic                     irq_n
);
    localparam int IEN_IDX = N_CTRL + N_STAT;
    localparam int IPEND_IDX = IEN_IDX + 1;
    localparam logic [ADDR_W-1:0] IEN_ADDR = ADDR_W'(IEN_IDX);
    localparam logic [ADDR_W-1:0] IPEND_ADDR = ADDR_W'(IPEND_IDX);

    target_e           tgt;
    logic              do_wr, do_rd;
    logic              hi_sel, held_hit;
    logic [BYTE_W-1:0] held_byte;
    logic [WORD_W-1:0] w_word, w_mask, live_word, rd_out;
    logic [N_IRQ-1:0]  irq_en_q, irq_pend_q;
    logic [WORD_W-1:0] ctrl_q [N_CTRL];

    // Qualified strobes.
    always_comb begin
        do_wr = cs & wr;
        do_rd = cs & rd;
    end

    // Full address decode onto a register class.
    always_comb begin
        tgt = TGT_NONE;
        for (int k = 0; k < N_CTRL; k++)
            if (addr == ADDR_W'(k)) tgt = TGT_CTRL;
        for (int k = 0; k < N_STAT; k++)
            if (addr == ADDR_W'(N_CTRL + k)) tgt = TGT_STAT;
        if (addr == IEN_ADDR) tgt = TGT_IEN;
        if (addr == IPEND_ADDR) tgt = TGT_IPEND;
    end

    regbus_lane u_lane (
        .mode8     (mode8),
        .wdata     (wdata),
        .rd_word   (live_word),
        .use_held  (held_hit),
        .held_byte (held_byte),
        .hi_sel    (hi_sel),
        .w_word    (w_word),
        .w_mask    (w_mask),
        .rd_out    (rd_out)
    );

    // Control registers, one per word address.
    for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[g] <= '0;
            else if (do_wr && addr == ADDR_W'(g))
                ctrl_q[g] <= (ctrl_q[g] & ~w_mask) | (w_word & w_mask);
        end
        assign ctrl_out[g*WORD_W +: WORD_W] = ctrl_q[g];
    end

    regbus_irq #(.N_IRQ(N_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .en_we   (do_wr && tgt == TGT_IEN),
        .pend_we (do_wr && tgt == TGT_IPEND),
        .w_word  (w_word[N_IRQ-1:0]),
        .w_mask  (w_mask[N_IRQ-1:0]),
        .en_q    (irq_en_q),
        .pend_q  (irq_pend_q),
        .irq_n   (irq_n)
    );

    // Live read mux; unassigned addresses read as zero.
    always_comb begin
        live_word = '0;
        for (int k = 0; k < N_CTRL; k++)
            if (addr == ADDR_W'(k)) live_word = ctrl_q[k];
        for (int k = 0; k < N_STAT; k++)
            if (addr == ADDR_W'(N_CTRL + k)) live_word = sts_in[k*WORD_W +: WORD_W];
        if (tgt == TGT_IEN) live_word = WORD_W'(irq_en_q);
        if (tgt == TGT_IPEND) live_word = WORD_W'(irq_pend_q);
    end

    regbus_rdlatch #(.ADDR_W(ADDR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (cs & (rd | wr)),
        .low_rd  (do_rd & ~wr & mode8 & ~hi_sel),
        .addr    (addr),
        .live_hi (live_word[WORD_W-1:BYTE_W]),
        .hit     (held_hit),
        .held    (held_byte)
    );

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (do_rd)
            rdata <= rd_out;
    end
endmodule

// File: rtl/regbus_chk.sv
// Module: property checker for regbus_front, attached with bind below.
module regbus_chk #(
    parameter int ADDR_W = 4,
    parameter int N_CTRL = 4,
    parameter int N_STAT = 2,
    parameter int N_IRQ  = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode8,
    input logic                 cs,
    input logic                 rd,
    input logic                 wr,
    input logic [ADDR_W-1:0]    addr,
    input logic [15:0]          rdata,
    input logic [N_IRQ-1:0]     evt,
    input logic [N_CTRL*16-1:0] ctrl_out,
    input logic [N_IRQ-1:0]     en_q,
    input logic [N_IRQ-1:0]     pend_q,
    input logic                 irq_n
);
    localparam logic [ADDR_W-1:0] FIRST_FREE = ADDR_W'(N_CTRL + N_STAT + 2);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(N_CTRL + N_STAT + 1);

    // R1: a reset edge leaves rdata zero and the request inactive.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0) && irq_n);

    // R2: control registers change only on a host write.
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr) |=> $stable(ctrl_out));

    // R4: byte-wide reads keep the upper data lines at zero.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && mode8) |=> rdata[15:8] == 8'h00);

    // R7: unassigned addresses read as zero.
    a_r7_free_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr >= FIRST_FREE) |=> rdata == '0);

    // R9: without a write to the pending address, pending bits only accumulate.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr && addr == PEND_ADDR) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R10: an enabled event raises the request at the next edge.
    a_r10_evt_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & en_q) != '0 && !(cs && wr)) |=> !irq_n);
endmodule

bind regbus_front regbus_chk #(
    .ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .N_STAT(N_STAT), .N_IRQ(N_IRQ)
) i_chk (
    .clk(clk), .rst_n(rst_n), .mode8(mode8), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .rdata(rdata), .evt(evt), .ctrl_out(ctrl_out),
    .en_q(irq_en_q), .pend_q(irq_pend_q), .irq_n(irq_n)
);

// File: tb/test_regbus_front.sv
module test_regbus_front;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NC = 4;
    localparam int NS = 2;
    localparam int NI = 12;
    localparam int IEN = NC + NS;
    localparam int IPD = NC + NS + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode8 = 1'b0;
    logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [NS*16-1:0] sts_in = '0;
    logic [NI-1:0] evt = '0;
    logic [NC*16-1:0] ctrl_out;
    logic          irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] ctrl_m [NC];
    logic [15:0] en_m, pend_m, got;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbus_front #(.ADDR_W(AW), .N_CTRL(NC), .N_STAT(NS), .N_IRQ(NI)) i_regbus_front (
        .clk(clk), .rst_n(rst_n), .mode8(mode8), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sts_in(sts_in), .evt(evt),
        .ctrl_out(ctrl_out), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic r, input logic w, input int a, input logic [15:0] d);
        @(negedge clk);
        cs = 1'b1; rd = r; wr = w; addr = AW'(a); wdata = d;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    task automatic wr16(input int a, input logic [15:0] d);
        acc(1'b0, 1'b1, a, d);
    endtask

    task automatic rd16(input int a, output logic [15:0] q);
        acc(1'b1, 1'b0, a, 16'h0000);
        q = rdata;
    endtask

    task automatic wr8(input int a, input bit hi, input logic [7:0] b);
        acc(1'b0, 1'b1, a, {hi, 7'h00, b});
    endtask

    task automatic rd8(input int a, input bit hi, output logic [15:0] q);
        acc(1'b1, 1'b0, a, {hi, 15'h0000});
        q = rdata;
    endtask

    task automatic pulse(input logic [NI-1:0] p);
        @(negedge clk);
        evt = p;
        @(negedge clk);
        evt = '0;
    endtask

    function automatic logic [15:0] model(input int a);
        if (a < NC) return ctrl_m[a];
        if (a < NC + NS) return sts_in[(a-NC)*16 +: 16];
        if (a == IEN) return en_m;
        if (a == IPD) return pend_m;
        return 16'h0000;
    endfunction

    task automatic sweep_map(input string req);
        for (int a = 0; a < (1 << AW); a++) begin
            rd16(a, got);
            chk(req, got, model(a));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NC; k++) ctrl_m[k] = '0;
        en_m = '0; pend_m = '0;
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk("R1 rdata", rdata, 16'h0000);
        chk("R1 irq_n", {15'h0, irq_n}, 16'h0001);
        chk("R1 ctrl", ctrl_out[15:0] | ctrl_out[63:48], 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        sts_in = {16'hBEEF, 16'h1234};

        // R2: 16-bit writes and reads to every control register
        for (int a = 0; a < NC; a++) begin
            ctrl_m[a] = 16'hA5C3 ^ 16'(a * 16'h1111);
            wr16(a, ctrl_m[a]);
        end
        for (int a = 0; a < NC; a++) begin
            rd16(a, got);
            chk("R2 word readback", got, ctrl_m[a]);
        end
        chk("R2 ctrl_out", ctrl_out[31:16], ctrl_m[1]);

        // R7 and R8: writes to free and status addresses, then a full map sweep
        for (int a = NC; a < (1 << AW); a++)
            if (a != IEN && a != IPD) wr16(a, 16'hFFFF);
        sweep_map("R7 R8 map after stray writes");
        sts_in = {16'h0F0F, 16'hC0DE};
        rd16(NC, got);
        chk("R8 status live", got, 16'hC0DE);
        rd16(NC + 1, got);
        chk("R8 status live", got, 16'h0F0F);

        // R3 and R4: byte writes on both lanes, byte reads back
        mode8 = 1'b1;
        for (int a = 0; a < NC; a++) begin
            for (int h = 0; h < 2; h++) begin
                logic [7:0] b;
                b = 8'(8'h3C + a * 8'd17 + h * 8'd101);
                wr8(a, h[0], b);
                if (h == 1) ctrl_m[a][15:8] = b; else ctrl_m[a][7:0] = b;
                rd8(a, 1'b0, got);
                chk("R3 R4 low byte", got, {8'h00, ctrl_m[a][7:0]});
                rd8(a, 1'b1, got);
                chk("R3 R4 high byte", got, {8'h00, ctrl_m[a][15:8]});
            end
        end
        wr8(NC, 1'b0, 8'h55);
        rd8(NC, 1'b0, got);
        chk("R8 byte write ignored", got, 16'h00DE);

        // R5: high byte comes from the latch after a low-byte read
        sts_in[15:0] = 16'h1234;
        rd8(NC, 1'b0, got);
        chk("R5 low byte", got, 16'h0034);
        sts_in[15:0] = 16'h5678;
        rd8(NC, 1'b1, got);
        chk("R5 latched high byte", got, 16'h0012);

        // R6: a second high read, a read of another address or a write releases the latch
        sts_in[15:0] = 16'h9ABC;
        rd8(NC, 1'b1, got);
        chk("R6 repeat high is live", got, 16'h009A);
        rd8(NC, 1'b0, got);
        sts_in[15:0] = 16'h7711;
        rd8(0, 1'b0, got);
        rd8(NC, 1'b1, got);
        chk("R6 other address between", got, 16'h0077);
        rd8(NC, 1'b0, got);
        sts_in[15:0] = 16'h2299;
        wr8(1, 1'b0, 8'h44);
        ctrl_m[1][7:0] = 8'h44;
        rd8(NC, 1'b1, got);
        chk("R6 write between", got, 16'h0022);
        rd8(NC + 1, 1'b0, got);
        sts_in[31:16] = 16'hAA00;
        rd8(NC, 1'b1, got);
        chk("R6 latch is per address", got, 16'h0022);

        // R7: byte writes to free addresses
        for (int a = IPD + 1; a < (1 << AW); a++) wr8(a, a[0], 8'hFF);
        mode8 = 1'b0;
        sweep_map("R7 map after byte stray writes");

        // R9 and R10: enable register masked to N_IRQ bits
        wr16(IEN, 16'hFFFF);
        rd16(IEN, got);
        chk("R9 enable width", got, 16'h0FFF);
        en_m = 16'h0A5A;
        wr16(IEN, en_m);
        chk("R10 idle", {15'h0, irq_n}, 16'h0001);
        for (int i = 0; i < NI; i++) begin
            logic [15:0] bit_i;
            bit_i = 16'(1 << i);
            pulse(NI'(bit_i));
            chk("R10 request", {15'h0, irq_n}, {15'h0, ~en_m[i]});
            rd16(IPD, got);
            chk("R9 pending set", got, bit_i);
            wr16(IPD, 16'h0000);
            rd16(IPD, got);
            chk("R9 zero write keeps", got, bit_i);
            mode8 = 1'b1;
            wr8(IPD, i >= 8, i >= 8 ? bit_i[15:8] : bit_i[7:0]);
            mode8 = 1'b0;
            chk("R10 released", {15'h0, irq_n}, 16'h0001);
            rd16(IPD, got);
            chk("R9 cleared", got, 16'h0000);
        end
        // R10: a masked pending bit raises the request once enabled
        pulse(NI'(16'h0001));
        chk("R10 masked", {15'h0, irq_n}, 16'h0001);
        en_m = 16'h0001;
        wr16(IEN, en_m);
        chk("R10 unmasked", {15'h0, irq_n}, 16'h0000);
        pend_m = 16'h0001;
        sweep_map("R9 final map");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule